// File: doc/BRIEF.md
# Debug Serial Line Error Monitor

This block sits beside a bit-timed receiver and transmitter on a single-wire, open-drain, half-duplex debug line. It watches for three faults: a long low stretch that means the host is sending a break, a received character whose stop bit came back low, and a collision in which this side lets the line float high while something else pulls it low. When any fault is seen, the block issues a one-cycle abort to cancel the current debug command, pulses a reset to the auto-baud logic, and pulls the line low for four character times. This tells the host that the exchange was lost.

A break from the host also holds the debug logic in reset until the host lets the line go high again. The block has no debug control register and does not touch one, so a break leaves the debug mode state to the logic that owns it. The bit-tick strobe comes from the existing baud timing. Every count in this block is in units of that strobe.

Top module: `dbg_line_monitor`

## Requirements
- R1: After reset, abortPulse, baudReset, breakDrive and holdReset are all low.
- R2: When the line is sampled low on 9 consecutive bit ticks, abortPulse, baudReset and holdReset go high on the clock edge that samples the ninth low tick. Eight low ticks raise none of them.
- R3: A bit tick that samples the line high restarts the count of consecutive low ticks.
- R4: A stop-bit strobe (stopValid=1) with stopBit=0 raises abortPulse on the next edge. A strobe with stopBit=1, or stopBit=0 without the strobe, raises nothing.
- R5: A bit tick with txActive=1 and txDrive=1 (line released) that samples the line low counts as a collision and raises abortPulse. With txActive=0, or with txDrive=0, a low line is not a collision.
- R6: After a fault, breakDrive rises on the same edge as abortPulse. It stays high through exactly 40 bit ticks (4 characters of 10 bits) and falls on the edge of the 40th tick.
- R7: After a host break, holdReset stays high until the echo has ended and the line is sampled high. It then falls on the next edge.
- R8: While breakDrive or holdReset is high, no new fault is taken: abortPulse does not pulse again.
- R9: A host break is detected while this side is transmitting (txActive=1, driving low).
- R10: abortPulse and baudReset are single-cycle pulses that rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Sampled level of the debug line |
| bitTick | input | 1 | One-cycle strobe per bit time |
| txActive | input | 1 | Transmitter is sending a character |
| txDrive | input | 1 | Level the transmitter drives (1 = release) |
| stopValid | input | 1 | Receiver is sampling a stop bit this cycle |
| stopBit | input | 1 | Sampled stop-bit level |
| abortPulse | output | 1 | Cancel the command in progress |
| baudReset | output | 1 | Reset pulse to the auto-baud logic |
| breakDrive | output | 1 | Pull the line low (echoed break) |
| holdReset | output | 1 | Hold debug logic in reset during host break |

## Verification
The assertions assume that bitTick is a single-cycle strobe and that lineIn shows the wired-AND of both drivers, so the line reads low whenever breakDrive is high. The bench builds lineIn from its own host-pull variable, the transmitter drive and breakDrive, so this always holds. The bench changes stimulus only on falling clock edges. It lets every echo run to the end before starting the next fault, except in the tests that aim faults into the echo and hold windows on purpose.

// File: rtl/dbgmon_pkg.sv
package dbgmon_pkg;

  typedef enum logic [0:0] {
    ST_WATCH = 1'b0,
    ST_ECHO  = 1'b1
  } monState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEcho;
    logic clearLow;
  } ctlStrobe_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic breakSeen;
    logic framingSeen;
    logic collisionSeen;
    logic echoLast;
  } lineStatus_t;

endpackage

// File: rtl/dbgmon_datapath.sv
module dbgmon_datapath
  import dbgmon_pkg::*;
#(
  parameter int BREAK_BITS = 9,
  parameter int ECHO_BITS  = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineIn,
  input  logic        bitTick,
  input  logic        txActive,
  input  logic        txDrive,
  input  logic        stopValid,
  input  logic        stopBit,
  input  ctlStrobe_t  ctl,
  output lineStatus_t status
);

  localparam int LW = $clog2(BREAK_BITS + 1);
  localparam int EW = $clog2(ECHO_BITS + 1);
  localparam logic [LW-1:0] LOW_MAX = LW'(BREAK_BITS);
  localparam logic [LW-1:0] LOW_HIT = LW'(BREAK_BITS - 1);
  localparam logic [EW-1:0] ECHO_LOAD = EW'(ECHO_BITS - 1);

  logic [LW-1:0] lowCnt;
  logic [EW-1:0] echoCnt;

  // consecutive-low counter, in bit ticks
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearLow) begin
      lowCnt <= '0;
    end else if (bitTick) begin
      if (lineIn)                lowCnt <= '0;
      else if (lowCnt != LOW_MAX) lowCnt <= lowCnt + 1'b1;
    end
  end

  // remaining ticks of the echoed break
  always_ff @(posedge clk) begin
    if (!rstN) begin
      echoCnt <= '0;
    end else if (ctl.loadEcho) begin
      echoCnt <= ECHO_LOAD;
    end else if (bitTick && echoCnt != '0) begin
      echoCnt <= echoCnt - 1'b1;
    end
  end

  always_comb begin
    status.breakSeen     = bitTick && !lineIn && (lowCnt == LOW_HIT);
    status.framingSeen   = stopValid && !stopBit;
    status.collisionSeen = bitTick && txActive && txDrive && !lineIn;
    status.echoLast      = bitTick && (echoCnt == '0);
  end

endmodule

// File: rtl/dbgmon_control.sv
module dbgmon_control
  import dbgmon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineIn,
  input  lineStatus_t status,
  output ctlStrobe_t  ctl,
  output logic        abortPulse,
  output logic        baudReset,
  output logic        breakDrive,
  output logic        holdReset
);

  monState_t state, stateNext;
  logic holdFlag;
  logic quiet;
  logic anyErr;

  assign quiet  = (state == ST_WATCH) && !holdFlag;
  assign anyErr = quiet && (status.breakSeen || status.framingSeen ||
                            status.collisionSeen);

  always_comb begin
    ctl.loadEcho = anyErr;
    ctl.clearLow = (state == ST_ECHO) || holdFlag || anyErr;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_WATCH: if (anyErr)          stateNext = ST_ECHO;
      ST_ECHO:  if (status.echoLast) stateNext = ST_WATCH;
      default:                       stateNext = ST_WATCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_WATCH;
      holdFlag   <= 1'b0;
      abortPulse <= 1'b0;
      baudReset  <= 1'b0;
    end else begin
      state      <= stateNext;
      abortPulse <= anyErr;
      baudReset  <= anyErr;
      if (quiet && status.breakSeen)
        holdFlag <= 1'b1;
      else if (holdFlag && state == ST_WATCH && lineIn)
        holdFlag <= 1'b0;
    end
  end

  assign breakDrive = (state == ST_ECHO);
  assign holdReset  = holdFlag;

endmodule

// File: rtl/dbg_line_monitor.sv
module dbg_line_monitor
  import dbgmon_pkg::*;
#(
  parameter int BREAK_BITS = 9,
  parameter int CHAR_BITS  = 10,
  parameter int ECHO_CHARS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  input  logic bitTick,
  input  logic txActive,
  input  logic txDrive,
  input  logic stopValid,
  input  logic stopBit,
  output logic abortPulse,
  output logic baudReset,
  output logic breakDrive,
  output logic holdReset
);

  localparam int ECHO_BITS = CHAR_BITS * ECHO_CHARS;

  ctlStrobe_t  ctl;
  lineStatus_t status;

  dbgmon_datapath #(.BREAK_BITS(BREAK_BITS), .ECHO_BITS(ECHO_BITS)) dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .bitTick(bitTick),
    .txActive(txActive), .txDrive(txDrive), .stopValid(stopValid),
    .stopBit(stopBit), .ctl(ctl), .status(status)
  );

  dbgmon_control ctrl (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .status(status), .ctl(ctl),
    .abortPulse(abortPulse), .baudReset(baudReset),
    .breakDrive(breakDrive), .holdReset(holdReset)
  );

endmodule

// File: rtl/dbg_line_monitor_chk.sv
module dbg_line_monitor_chk #(
  parameter int ECHO_BITS = 40
) (
  input logic clk,
  input logic rstN,
  input logic lineIn,
  input logic bitTick,
  input logic abortPulse,
  input logic baudReset,
  input logic breakDrive,
  input logic holdReset
);

  logic [15:0] echoTicks;

  always_ff @(posedge clk) begin
    if (!rstN || !breakDrive) echoTicks <= '0;
    else if (bitTick)         echoTicks <= echoTicks + 1'b1;
  end

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse);

  assert_echo_starts_with_abort_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakDrive) |-> abortPulse);

  assert_echo_length_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(breakDrive) |-> (echoTicks == 16'(ECHO_BITS)));

  assert_echo_bounded_R6: assert property (@(posedge clk) disable iff (!rstN)
    breakDrive |-> (echoTicks < 16'(ECHO_BITS)));

  assert_no_abort_in_echo_R8: assert property (@(posedge clk) disable iff (!rstN)
    (breakDrive && !$rose(breakDrive)) |-> !abortPulse);

  assert_hold_starts_with_pulses_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdReset) |-> (abortPulse && baudReset));

  assert_hold_ends_on_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdReset) |-> ($past(lineIn) && !breakDrive));

endmodule

bind dbg_line_monitor dbg_line_monitor_chk #(.ECHO_BITS(CHAR_BITS * ECHO_CHARS)) chk (
  .clk(clk), .rstN(rstN), .lineIn(lineIn), .bitTick(bitTick),
  .abortPulse(abortPulse), .baudReset(baudReset),
  .breakDrive(breakDrive), .holdReset(holdReset)
);

// File: tb/dbg_line_monitor_test.sv
module dbg_line_monitor_test;

  logic clk = 1'b0;
  logic rstN;
  logic bitTick, txActive, txDrive, stopValid, stopBit, hostLow;
  logic lineIn;
  logic abortPulse, baudReset, breakDrive, holdReset;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // wired-AND of host, transmitter and echoed break
  assign lineIn = !(hostLow || breakDrive || (txActive && !txDrive));

  dbg_line_monitor uut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .bitTick(bitTick),
    .txActive(txActive), .txDrive(txDrive), .stopValid(stopValid),
    .stopBit(stopBit), .abortPulse(abortPulse), .baudReset(baudReset),
    .breakDrive(breakDrive), .holdReset(holdReset)
  );

  // {stopValid, stopBit, txActive, txDrive, hostLow, expectAbort}
  localparam logic [5:0] VECS [8] = '{
    6'b10_01_0_1,  // R4 framing error
    6'b11_01_0_0,  // R4 good stop bit
    6'b01_11_1_1,  // R5 collision
    6'b01_01_1_0,  // R5 not transmitting
    6'b01_10_1_0,  // R5 driving low
    6'b00_01_0_0,  // R4 low stop without strobe
    6'b01_11_0_0,  // R5 released, line high
    6'b10_11_0_1   // R4 framing while transmitting
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    bitTick = 0; txActive = 0; txDrive = 1; stopValid = 0; stopBit = 1;
    hostLow = 0;
  endtask

  // one clock with a bit tick, stimulus changed on the falling edge
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1;
      @(negedge clk);
    end
    bitTick = 0;
  endtask

  // run ticks until the echo ends; return the number of ticks
  task automatic runEcho(output int n);
    n = 0;
    bitTick = 1;
    while (breakDrive && n < 100) begin
      @(negedge clk);
      n++;
    end
    bitTick = 0;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    int n;
    int aborts;
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    check("R1 abortPulse", abortPulse, 0);
    check("R1 baudReset", baudReset, 0);
    check("R1 breakDrive", breakDrive, 0);
    check("R1 holdReset", holdReset, 0);
    rstN = 1;
    tick(2);

    // table of single-cycle fault patterns
    foreach (VECS[k]) begin
      {stopValid, stopBit, txActive, txDrive, hostLow} = VECS[k][5:1];
      bitTick = 1;
      @(negedge clk);
      check($sformatf("R4/R5 vector %0d abort", k), abortPulse, VECS[k][0]);
      idle();
      if (VECS[k][0]) begin
        check("R10 baudReset with abort", baudReset, 1);
        check("R6 echo rises with abort", breakDrive, 1);
        runEcho(n);
        check("R6 echo length 40", n == 40, 1);
      end
      tick(1);
    end

    // R3: eight low, one high, eight low -> nothing
    aborts = 0;
    hostLow = 1;
    for (int i = 0; i < 8; i++) begin bitTick = 1; @(negedge clk); aborts += abortPulse; end
    hostLow = 0; tick(1);
    hostLow = 1;
    for (int i = 0; i < 8; i++) begin bitTick = 1; @(negedge clk); aborts += abortPulse; end
    check("R3 no break after interrupted low", aborts == 0, 1);
    check("R2 eight low ticks no hold", holdReset, 0);

    // R2: ninth low tick after a high tick
    hostLow = 0; tick(1);
    hostLow = 1;
    tick(8);
    check("R2 no abort at eighth tick", abortPulse, 0);
    bitTick = 1; @(negedge clk); bitTick = 0;
    check("R2 abort at ninth tick", abortPulse, 1);
    check("R2 baudReset at ninth tick", baudReset, 1);
    check("R7 hold raised", holdReset, 1);
    @(negedge clk);
    check("R10 abort single cycle", abortPulse, 0);
    check("R10 baudReset single cycle", baudReset, 0);

    // R8: host keeps line low past the echo, plus a framing strobe
    aborts = 0;
    for (int i = 0; i < 60; i++) begin
      bitTick = 1;
      stopValid = (i == 50); stopBit = 0;
      @(negedge clk);
      aborts += abortPulse;
    end
    stopValid = 0; bitTick = 0;
    check("R8 no abort during hold", aborts == 0, 1);
    check("R7 hold while host low", holdReset, 1);
    check("R6 echo ended", breakDrive, 0);
    hostLow = 0;
    @(negedge clk);
    check("R7 hold released on high", holdReset, 0);

    // R8: faults inside an echo are ignored
    stopValid = 1; stopBit = 0; @(negedge clk); stopValid = 0;
    check("R4 framing abort", abortPulse, 1);
    aborts = 0;
    for (int i = 0; i < 20; i++) begin
      bitTick = 1; txActive = 1; txDrive = 1; stopValid = 1;
      @(negedge clk);
      aborts += abortPulse;
    end
    idle();
    check("R8 no abort during echo", aborts == 0, 1);
    runEcho(n);
    tick(1);

    // R9: break while transmitting a low bit
    txActive = 1; txDrive = 0;
    tick(9);
    check("R9 break during transmit abort", abortPulse, 1);
    check("R9 break during transmit hold", holdReset, 1);
    idle();
    runEcho(n);
    @(negedge clk);
    check("R7 hold clears after echo", holdReset, 0);

    finished = 1;
    summary();
  end

endmodule